// File: doc/BRIEF.md
# Serial Two-Wire Slave for a Protected Register File and Paged Array

This block is the serial-bus slave in front of two storage spaces: a clock/control register file and a byte array modelled as nonvolatile storage. It samples the two open-drain bus lines with the system clock. It recognises start and stop conditions, decodes two device addresses and loads a shared address counter from a two-byte word address. It then performs byte and page writes, random reads, current-address reads and sequential reads. It can also perform an address-only transaction that loads the counter and transfers no data.

Writes to the control file are guarded by two enable latches. Both are set through a status register in the last control-file location, by writing two codes in a fixed order. Array writes are committed as a self-timed write cycle that starts at the closing stop condition. While that cycle runs, the slave refuses both device addresses, so a host can poll for completion.

The pad drivers are outside the block. The block only asserts an active-high pull-low enable for SDA, and the board's pull-ups supply the high level.

Top module: `tw_prot_slave`

## Requirements
- R1: A device byte whose upper seven bits are 1010111 selects the array and 1101111 selects the control file; bit 0 is the read flag. The slave pulls SDA low in the ninth clock on a match and leaves it released otherwise.
- R2: In a write transaction the two bytes after the device byte form the word address. The array uses bit 0 of the first byte as address bit 8 and the second byte as bits 7..0. The control file uses bits 5..0 of the second byte. The counter is loaded when the second byte completes.
- R3: Data bytes after the word address are stored at the counter, which then advances in its low 4 bits only, so a page write wraps inside its 16-byte page.
- R4: A read transaction returns bytes starting at the counter, most significant bit first, and advances the counter after each byte. The array counter wraps from 511 to 0 and the control counter from 63 to 0. A random read (word address, repeated start, read) and a current-address read (read device byte alone) are both supported.
- R5: A stop after the word address loads the counter, writes nothing and starts no write cycle.
- R6: Control location 63 is the status register and reads as {5'b0, RWEL, WEL, 1'b0}. Writing 02h sets WEL and clears RWEL. Writing 06h while WEL is set sets RWEL. Any other write there clears both. These writes take effect at once.
- R7: A write to any other control location is stored only while both latches are set. Otherwise it is acknowledged and discarded.
- R8: A stop that ends a transaction containing at least one array data byte starts a write cycle of WR_CYCLES clocks. During the cycle both device addresses are refused. Control-file writes start no cycle.
- R9: After a refused device byte, or after the host refuses a read byte, the slave releases SDA and ignores the bus until the next start.
- R10: SDA is released in reset, and the pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | When high, the pad pulls SDA low |

## Verification
The assertions assume that the host behaves as a well-formed bus master. It changes SDA only while SCL is low, except when it signals a start or a stop, and it holds each SCL level for several system clocks so that the two-flop synchronisers pass every edge in order. The bench drives each SCL phase for six clocks and moves SDA one full phase after the SCL falling edge. Because of that spacing, the slave's own drive changes can never look like a start or stop condition. A host that resets the bus in the middle of a byte is not exercised.

// File: rtl/tw_prot_pkg.sv
package tw_prot_pkg;
    localparam logic [6:0] ARR_DEV_ID = 7'b1010111;
    localparam logic [6:0] CTL_DEV_ID = 7'b1101111;
    localparam logic [7:0] CODE_WEL   = 8'h02;
    localparam logic [7:0] CODE_RWEL  = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK1, ST_ACK2, ST_TX, ST_MACK
    } phase_e;
endpackage

// File: rtl/tw_line_mon.sv
module tw_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_sync_q, sda_sync_q;
    logic       scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= 2'b11;
            sda_sync_q <= 2'b11;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[0], scl_i};
            sda_sync_q <= {sda_sync_q[0], sda_i};
            scl_prev_q <= scl_sync_q[1];
            sda_prev_q <= sda_sync_q[1];
        end
    end

    assign scl_lvl  = scl_sync_q[1];
    assign sda_lvl  = sda_sync_q[1];
    assign scl_rise = scl_lvl & ~scl_prev_q;
    assign scl_fall = ~scl_lvl & scl_prev_q;
    assign start_ev = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
endmodule

// File: rtl/tw_nv_store.sv
module tw_nv_store #(
    parameter int ARR_BYTES = 512,
    parameter int WR_CYCLES = 300,
    localparam int AW = $clog2(ARR_BYTES),
    localparam int BW = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          cycle_start,
    output logic          busy
);
    logic [7:0]    mem_q [ARR_BYTES];
    logic [BW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cycle_start)        cnt_d = BW'(WR_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < ARR_BYTES; i++) mem_q[i] <= 8'h00;
        end else begin
            cnt_q <= cnt_d;
            if (we) mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
    assign busy  = (cnt_q != '0);

    p_cycle_begins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> busy);
endmodule

// File: rtl/tw_ctl_regs.sv
module tw_ctl_regs
    import tw_prot_pkg::*;
#(
    parameter int CTL_BYTES = 64,
    localparam int CW = $clog2(CTL_BYTES),
    localparam logic [CW-1:0] STAT_ADDR = CW'(CTL_BYTES - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [CW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] regs_q [CTL_BYTES];
    logic       wel_q, wel_d, rwel_q, rwel_d;
    logic       reg_wr;

    always_comb begin
        wel_d  = wel_q;
        rwel_d = rwel_q;
        reg_wr = 1'b0;
        if (we && waddr == STAT_ADDR) begin
            if (wdata == CODE_WEL) begin
                wel_d  = 1'b1;
                rwel_d = 1'b0;
            end else if (wdata == CODE_RWEL && wel_q) begin
                rwel_d = 1'b1;
            end else begin
                wel_d  = 1'b0;
                rwel_d = 1'b0;
            end
        end else if (we) begin
            reg_wr = wel_q & rwel_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
            for (int i = 0; i < CTL_BYTES; i++) regs_q[i] <= 8'h00;
        end else begin
            wel_q  <= wel_d;
            rwel_q <= rwel_d;
            if (reg_wr) regs_q[waddr] <= wdata;
        end
    end

    assign rdata = (raddr == STAT_ADDR) ? {5'b0, rwel_q, wel_q, 1'b0} : regs_q[raddr];

    p_rwel_implies_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_q |-> wel_q);
    p_locked_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != STAT_ADDR && !rwel_q) |=> regs_q[$past(waddr)] == $past(regs_q[waddr]));
endmodule

// File: rtl/tw_prot_slave.sv
module tw_prot_slave
    import tw_prot_pkg::*;
#(
    parameter int ARR_BYTES  = 512,
    parameter int PAGE_BYTES = 16,
    parameter int CTL_BYTES  = 64,
    parameter int WR_CYCLES  = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int AW = $clog2(ARR_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(CTL_BYTES);
    localparam int HW = AW - 8;

    typedef struct packed {
        phase_e        st;
        logic [2:0]    bcnt;
        logic [7:0]    sh;
        logic [1:0]    idx;
        logic          ctl;
        logic          txm;
        logic          ackf;
        logic          drive;
        logic          pend;
        logic [HW-1:0] hi;
        logic [AW-1:0] addr;
    } fsm_t;

    fsm_t s_q, s_d;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic arr_we, ctl_we, cyc_start, busy;
    logic [7:0] wdata, arr_rdata, ctl_rdata, rdat, rx_byte;

    tw_line_mon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    tw_nv_store #(.ARR_BYTES(ARR_BYTES), .WR_CYCLES(WR_CYCLES)) u_nv (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(s_q.addr), .wdata(wdata),
        .raddr(s_q.addr), .rdata(arr_rdata), .cycle_start(cyc_start), .busy(busy)
    );

    tw_ctl_regs #(.CTL_BYTES(CTL_BYTES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .waddr(s_q.addr[CW-1:0]), .wdata(wdata),
        .raddr(s_q.addr[CW-1:0]), .rdata(ctl_rdata)
    );

    assign rdat    = s_q.ctl ? ctl_rdata : arr_rdata;
    assign rx_byte = {s_q.sh[6:0], sda_lvl};
    assign wdata   = rx_byte;

    function automatic logic [AW-1:0] rd_next(input logic ctl, input logic [AW-1:0] a);
        if (ctl) return AW'(a[CW-1:0] + 1'b1);
        return a + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        arr_we    = 1'b0;
        ctl_we    = 1'b0;
        cyc_start = 1'b0;
        if (stop_ev) begin
            s_d.st    = ST_IDLE;
            s_d.drive = 1'b0;
            cyc_start = s_q.pend;
            s_d.pend  = 1'b0;
        end else if (start_ev) begin
            s_d.st    = ST_RX;
            s_d.bcnt  = '0;
            s_d.idx   = '0;
            s_d.txm   = 1'b0;
            s_d.drive = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_RX: if (scl_rise) begin
                    s_d.sh   = rx_byte;
                    s_d.bcnt = s_q.bcnt + 3'd1;
                    if (s_q.bcnt == 3'd7) begin
                        s_d.st   = ST_ACK1;
                        s_d.ackf = 1'b1;
                        unique case (s_q.idx)
                            2'd0: begin
                                s_d.ctl  = (rx_byte[7:1] == CTL_DEV_ID);
                                s_d.ackf = ((rx_byte[7:1] == ARR_DEV_ID) ||
                                            (rx_byte[7:1] == CTL_DEV_ID)) && !busy;
                                s_d.txm  = rx_byte[0];
                                s_d.idx  = 2'd1;
                            end
                            2'd1: begin
                                s_d.hi  = rx_byte[HW-1:0];
                                s_d.idx = 2'd2;
                            end
                            2'd2: begin
                                s_d.addr = s_q.ctl ? AW'(rx_byte[CW-1:0]) : {s_q.hi, rx_byte};
                                s_d.idx  = 2'd3;
                            end
                            default: begin
                                if (s_q.ctl) begin
                                    ctl_we   = 1'b1;
                                    s_d.addr = rd_next(1'b1, s_q.addr);
                                end else begin
                                    arr_we   = 1'b1;
                                    s_d.pend = 1'b1;
                                    s_d.addr = {s_q.addr[AW-1:PW], s_q.addr[PW-1:0] + 1'b1};
                                end
                            end
                        endcase
                    end
                end
                ST_ACK1: if (scl_fall) begin
                    s_d.drive = s_q.ackf;
                    s_d.st    = ST_ACK2;
                end
                ST_ACK2: if (scl_fall) begin
                    s_d.bcnt = '0;
                    if (!s_q.ackf) begin
                        s_d.st    = ST_IDLE;
                        s_d.drive = 1'b0;
                    end else if (s_q.txm) begin
                        s_d.st    = ST_TX;
                        s_d.sh    = rdat;
                        s_d.drive = ~rdat[7];
                        s_d.addr  = rd_next(s_q.ctl, s_q.addr);
                    end else begin
                        s_d.st    = ST_RX;
                        s_d.drive = 1'b0;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (s_q.bcnt == 3'd7) begin
                        s_d.drive = 1'b0;
                        s_d.st    = ST_MACK;
                    end else begin
                        s_d.drive = ~s_q.sh[6];
                        s_d.sh    = {s_q.sh[6:0], 1'b0};
                        s_d.bcnt  = s_q.bcnt + 3'd1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    s_d.ackf = 1'b1;
                    s_d.st   = sda_lvl ? ST_IDLE : ST_ACK2;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe = s_q.drive;

    p_no_array_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !busy);
    p_drive_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.drive != $past(s_q.drive)) |-> !scl_lvl);
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) |-> !s_q.drive);
endmodule

// File: tb/tw_prot_slave_tb.sv
module tw_prot_slave_tb;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [512];
    logic [7:0] ctl_m [64];
    bit wel_m = 0, rwel_m = 0;
    int cnt_m = 0;

    always #4 clk = ~clk;

    tw_prot_slave u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R10 per-clock comparison: drive may not move while SCL stays high
    bit prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_scl && scl_m) chk(prev_oe == sda_oe, "R10 drive moved with SCL high", sda_oe, prev_oe);
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic waitq(); repeat (Q) @(negedge clk); endtask
    task automatic i2c_start();
        sda_m = 1; waitq(); scl_m = 1; waitq(); sda_m = 0; waitq(); scl_m = 0; waitq();
    endtask
    task automatic i2c_stop();
        sda_m = 0; waitq(); scl_m = 1; waitq(); sda_m = 1; waitq(); waitq();
    endtask
    task automatic bit_out(input bit b);
        sda_m = b; waitq(); scl_m = 1; waitq(); waitq(); scl_m = 0; waitq();
    endtask
    task automatic bit_in(output bit r);
        sda_m = 1; waitq(); scl_m = 1; waitq(); r = sda_bus; waitq(); scl_m = 0; waitq();
    endtask
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(r);
        ack = !r;
    endtask
    task automatic recv_byte(input bit last, output logic [7:0] b);
        bit r;
        for (int i = 7; i >= 0; i--) begin bit_in(r); b[i] = r; end
        bit_out(last);
    endtask

    function automatic logic [7:0] dev(input bit ctl, input bit rd);
        return ctl ? {7'b1101111, rd} : {7'b1010111, rd};
    endfunction
    function automatic logic [7:0] ctl_read_m(input int a);
        return (a == 63) ? {5'b0, rwel_m, wel_m, 1'b0} : ctl_m[a];
    endfunction

    // write n bytes (base + i*step); n = 0 is an address-only transaction
    task automatic wr_seq(input bit ctl, input logic [15:0] wa, input int n,
                          input logic [7:0] base, input int step, input string tag);
        bit ack;
        int a;
        logic [7:0] d;
        i2c_start();
        send_byte(dev(ctl, 0), ack); chk(ack, {tag, " device ack"}, ack, 1);
        send_byte(wa[15:8], ack);    chk(ack, {tag, " addr hi ack"}, ack, 1);
        send_byte(wa[7:0], ack);     chk(ack, {tag, " addr lo ack"}, ack, 1);
        a = ctl ? int'(wa[5:0]) : int'({wa[8], wa[7:0]});
        for (int i = 0; i < n; i++) begin
            d = base + 8'(i * step);
            send_byte(d, ack);
            chk(ack, {tag, " data ack"}, ack, 1);
            if (ctl) begin
                if (a == 63) begin
                    if (d == 8'h02) begin wel_m = 1; rwel_m = 0; end
                    else if (d == 8'h06 && wel_m) rwel_m = 1;
                    else begin wel_m = 0; rwel_m = 0; end
                end else if (wel_m && rwel_m) ctl_m[a] = d;
                a = (a + 1) % 64;
            end else begin
                mem_m[a] = d;
                a = (a & 'h1F0) | ((a + 1) & 'hF);
            end
        end
        cnt_m = a;
        i2c_stop();
    endtask

    task automatic rd_seq(input bit ctl, input bit with_addr, input logic [15:0] wa,
                          input int n, input string tag);
        bit ack;
        logic [7:0] b, e;
        if (with_addr) begin
            i2c_start();
            send_byte(dev(ctl, 0), ack); chk(ack, {tag, " device ack"}, ack, 1);
            send_byte(wa[15:8], ack);
            send_byte(wa[7:0], ack);
            cnt_m = ctl ? int'(wa[5:0]) : int'({wa[8], wa[7:0]});
        end
        i2c_start();
        send_byte(dev(ctl, 1), ack); chk(ack, {tag, " read device ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            e = ctl ? ctl_read_m(cnt_m % 64) : mem_m[cnt_m];
            chk(b == e, {tag, " read data"}, b, e);
            cnt_m = ctl ? ((cnt_m % 64) + 1) % 64 : (cnt_m + 1) % 512;
        end
        i2c_stop();
    endtask

    task automatic poll(input bit ctl, output bit ack);
        i2c_start();
        send_byte(dev(ctl, 0), ack);
        i2c_stop();
    endtask

    task automatic wait_ready(input string tag);
        bit ack;
        int tries = 0;
        poll(0, ack);
        chk(!ack, {tag, " address refused while busy"}, ack, 0);
        while (!ack && tries < 20) begin poll(0, ack); tries++; end
        chk(ack, {tag, " address accepted after cycle"}, ack, 1);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < 64; i++) ctl_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R10 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 / R9: foreign address refused, following byte ignored
        begin
            bit ack;
            i2c_start();
            send_byte(8'hA0, ack); chk(!ack, "R1 foreign address", ack, 0);
            send_byte(8'h00, ack); chk(!ack, "R9 bus ignored after refusal", ack, 0);
            i2c_stop();
        end

        // R3 / R8: byte write, busy refusal, random read (R2, R4)
        wr_seq(0, 16'h0123, 1, 8'h5A, 0, "R3 byte write");
        wait_ready("R8");
        rd_seq(0, 1, 16'h0123, 1, "R2 R4 random read");

        // R3: page write of 18 bytes wraps inside page 0x1F0
        wr_seq(0, 16'h01F5, 18, 8'h40, 1, "R3 page write");
        wait_ready("R8 page");
        rd_seq(0, 1, 16'h01F0, 16, "R3 page wrap readback");

        // R4: sequential read rolls 511 -> 0, then current-address read
        rd_seq(0, 1, 16'h01FE, 4, "R4 array rollover");
        rd_seq(0, 0, 16'h0000, 1, "R4 current address");

        // R5: address-only transaction loads counter, starts no cycle
        wr_seq(0, 16'h0080, 0, 8'h00, 0, "R5 set address");
        begin
            bit ack;
            poll(0, ack); chk(ack, "R5 no write cycle", ack, 1);
        end
        rd_seq(0, 0, 16'h0000, 1, "R5 current read at loaded address");

        // R7: locked write dropped; R6 status reads zero
        wr_seq(1, 16'h0010, 1, 8'h77, 0, "R7 locked write");
        rd_seq(1, 1, 16'h0010, 1, "R7 locked readback");
        rd_seq(1, 1, 16'h003F, 1, "R6 status idle");

        // R6: unlock sequence, then R7 accepted writes, R8 no busy from control writes
        wr_seq(1, 16'h003F, 1, 8'h02, 0, "R6 set WEL");
        rd_seq(1, 1, 16'h003F, 1, "R6 status after 02h");
        wr_seq(1, 16'h003F, 1, 8'h06, 0, "R6 set RWEL");
        rd_seq(1, 1, 16'h003F, 1, "R6 status after 06h");
        wr_seq(1, 16'h0010, 3, 8'hC1, 3, "R7 unlocked write");
        begin
            bit ack;
            poll(1, ack); chk(ack, "R8 control write starts no cycle", ack, 1);
        end
        rd_seq(1, 1, 16'h0010, 3, "R7 unlocked readback");

        // R6: other value clears both; R7 locked again
        wr_seq(1, 16'h003F, 1, 8'h00, 0, "R6 clear latches");
        wr_seq(1, 16'h0011, 1, 8'h99, 0, "R7 relocked write");
        rd_seq(1, 1, 16'h0011, 1, "R7 relocked readback");
        wr_seq(1, 16'h003F, 1, 8'h06, 0, "R6 06h without 02h");
        rd_seq(1, 1, 16'h003F, 1, "R6 status stays clear");

        // R4: control counter rolls 63 -> 0
        rd_seq(1, 1, 16'h003E, 3, "R4 control rollover");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule